// File: doc/BRIEF.md
# Per-Core Interrupt Router

This block takes the local interrupt lines of a four-core cluster and turns them into one IRQ and one FIQ request per core. Each core owns four timer lines, four mailbox lines (the block sees only "mailbox non-empty" levels) and one performance-monitor line. One interrupt pair from the graphics subsystem is shared by the whole cluster.

Software configures the routing through a small 32-bit register bus. Each timer or mailbox source has its own IRQ enable and its own FIQ enable. When both are set, the FIQ enable wins. The graphics IRQ and the graphics FIQ are each steered to one core chosen by a 2-bit field. The performance-monitor lines are enabled per core through a set port and a clear port, and they only ever raise FIQ. Software reads two status words per core that show which sources are currently asserting IRQ and FIQ.

The request outputs are levels. They are combinational from the registered configuration and the input lines, so a source that rises or falls shows on the outputs in the same cycle.

Top module: `core_irq_router`

## Requirements
- R1: After reset every timer, mailbox and performance-monitor enable is zero. Control registers read 0, and no timer, mailbox or performance-monitor line reaches any output.
- R2: In a core's timer control register, bit n (n = 0..3) enables timer line n of that core as IRQ. The source then appears in bit n of that core's IRQ status word.
- R3: In a core's timer control register, bit 4+n enables timer line n as FIQ. The source then appears in bit n of the FIQ status word and is removed from the IRQ status word, whatever the IRQ enable holds.
- R4: A core's mailbox control register works the same way. Bits 3:0 are the IRQ enables and bits 7:4 are the FIQ enables, with FIQ winning. Mailbox line m appears in status bit 4+m.
- R5: Bits 1:0 of the graphics routing register (offset 0x0C) pick the core whose IRQ status bit 8 follows the graphics IRQ input. No other core sees it. The field resets to 0, which selects core 0.
- R6: Bits 3:2 of the graphics routing register pick the single core whose FIQ status bit 8 follows the graphics FIQ input.
- R7: Writing to offset 0x10 sets the performance-monitor enable of core n for every 1 in wdata bit n. Writing to offset 0x14 clears it for every 1. Zero bits leave an enable unchanged. Reading either offset returns the enable mask.
- R8: An enabled performance-monitor line appears in bit 9 of its core's FIQ status word. Bit 9 of an IRQ status word is always 0.
- R9: A core's IRQ output is the OR of its IRQ status word, and its FIQ output is the OR of its FIQ status word. Both follow input lines in the same cycle, with no clock edge in between.
- R10: The per-core registers are spaced 4 bytes apart: timer control at 0x40+4n, mailbox control at 0x50+4n, IRQ status at 0x60+4n, FIQ status at 0x70+4n. A read returns data in bus_rdata one cycle after bus_rd. Only bits 7:0 of a control register are kept. Unmapped offsets read 0, and writes to status words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| timer_lines | input | 16 | Timer levels, 4 per core, core n at bits 4n+3:4n |
| mbox_lines | input | 16 | Mailbox non-empty levels, 4 per core, core n at bits 4n+3:4n |
| pmu_lines | input | 4 | Performance-monitor level per core |
| gpu_irq | input | 1 | Shared graphics IRQ level |
| gpu_fiq | input | 1 | Shared graphics FIQ level |
| core_irq | output | 4 | IRQ request per core |
| core_fiq | output | 4 | FIQ request per core |

## Verification
Several properties are checked on every cycle. No source is counted as IRQ while its FIQ enable is set. At most one core sees the graphics IRQ. IRQ status bit 9 stays clear. The set and clear ports change the performance-monitor mask in the cycle after the write. The enables are also checked to be clear right after reset.

Other behaviours only show up in the bench's scenarios. These are the exact bit positions in the status words, the per-core address stride, the default routing of graphics interrupts to core 0, the dropping of upper control bits, the ignoring of writes to status registers and zero bits on the set port, and the same-cycle response of the request outputs.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
    localparam int SRC_W  = 4;   // lines per source bank
    localparam int CTL_W  = 8;   // kept bits of a control register
    localparam int PEND_W = 10;  // status word width
    localparam int SEL_W  = 2;   // core select field width

    localparam int BIT_MBX0 = 4;
    localparam int BIT_GPU  = 8;
    localparam int BIT_PMU  = 9;

    localparam logic [7:0] OFS_GPU_ROUTE = 8'h0C;
    localparam logic [7:0] OFS_PMU_SET   = 8'h10;
    localparam logic [7:0] OFS_PMU_CLR   = 8'h14;

    localparam logic [3:0] GRP_TMR   = 4'h4;
    localparam logic [3:0] GRP_MBX   = 4'h5;
    localparam logic [3:0] GRP_IPEND = 4'h6;
    localparam logic [3:0] GRP_FPEND = 4'h7;

    typedef struct packed {
        logic [SEL_W-1:0] fiq_core;
        logic [SEL_W-1:0] irq_core;
    } gpu_route_t;
endpackage

// File: rtl/cirq_steer.sv
module cirq_steer
    import cirq_pkg::*;
#(
    parameter int NSRC = SRC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   lines,
    input  logic [2*NSRC-1:0] ctl,
    output logic [NSRC-1:0]   irq_hit,
    output logic [NSRC-1:0]   fiq_hit
);
    logic [NSRC-1:0] irq_en;
    logic [NSRC-1:0] fiq_en;

    assign irq_en = ctl[NSRC-1:0];
    assign fiq_en = ctl[2*NSRC-1:NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_comb begin
            fiq_hit[i] = lines[i] & fiq_en[i];
            irq_hit[i] = lines[i] & irq_en[i] & ~fiq_en[i];
        end

        // R3 / R4: a FIQ enable keeps the source out of IRQ
        a_r3_fiq_wins: assert property (@(posedge clk) disable iff (rst)
            ctl[NSRC+i] |-> !irq_hit[i]);
    end
endmodule

// File: rtl/cirq_core_route.sv
module cirq_core_route
    import cirq_pkg::*;
#(
    parameter int CORE_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  tmr_lines,
    input  logic [SRC_W-1:0]  mbx_lines,
    input  logic [CTL_W-1:0]  tmr_ctl,
    input  logic [CTL_W-1:0]  mbx_ctl,
    input  gpu_route_t        gpu_route,
    input  logic              gpu_irq,
    input  logic              gpu_fiq,
    input  logic              pmu_en,
    input  logic              pmu_line,
    output logic [PEND_W-1:0] irq_pend,
    output logic [PEND_W-1:0] fiq_pend,
    output logic              irq_req,
    output logic              fiq_req
);
    localparam logic [SEL_W-1:0] MY_ID = SEL_W'(CORE_ID);

    logic [SRC_W-1:0] t_irq, t_fiq, m_irq, m_fiq;

    cirq_steer #(.NSRC(SRC_W)) u_tmr (
        .clk(clk), .rst(rst), .lines(tmr_lines), .ctl(tmr_ctl),
        .irq_hit(t_irq), .fiq_hit(t_fiq)
    );

    cirq_steer #(.NSRC(SRC_W)) u_mbx (
        .clk(clk), .rst(rst), .lines(mbx_lines), .ctl(mbx_ctl),
        .irq_hit(m_irq), .fiq_hit(m_fiq)
    );

    always_comb begin
        irq_pend = '0;
        fiq_pend = '0;
        irq_pend[SRC_W-1:0]               = t_irq;
        fiq_pend[SRC_W-1:0]               = t_fiq;
        irq_pend[BIT_MBX0+SRC_W-1:BIT_MBX0] = m_irq;
        fiq_pend[BIT_MBX0+SRC_W-1:BIT_MBX0] = m_fiq;
        irq_pend[BIT_GPU] = gpu_irq && (gpu_route.irq_core == MY_ID);
        fiq_pend[BIT_GPU] = gpu_fiq && (gpu_route.fiq_core == MY_ID);
        fiq_pend[BIT_PMU] = pmu_en && pmu_line;
    end

    assign irq_req = |irq_pend;
    assign fiq_req = |fiq_pend;
endmodule

// File: rtl/cirq_regs.sv
module cirq_regs
    import cirq_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NCORE-1:0][PEND_W-1:0]  irq_pend,
    input  logic [NCORE-1:0][PEND_W-1:0]  fiq_pend,
    output logic [NCORE-1:0][CTL_W-1:0]   tmr_ctl,
    output logic [NCORE-1:0][CTL_W-1:0]   mbx_ctl,
    output gpu_route_t                    gpu_route,
    output logic [NCORE-1:0]              pmu_en
);
    localparam int ROUTE_W = 2 * SEL_W;

    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] unused_wdata;

    assign unused_wdata = bus_wdata;

    function automatic logic [ADDR_W-1:0] reg_ofs(input logic [3:0] grp, input int core);
        return ADDR_W'({grp, 4'(core * 4)});
    endfunction

    // write side
    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_ctl   <= '0;
            mbx_ctl   <= '0;
            gpu_route <= '0;
            pmu_en    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_GPU_ROUTE)
                gpu_route <= gpu_route_t'(bus_wdata[ROUTE_W-1:0]);
            if (bus_addr == OFS_PMU_SET)
                pmu_en <= pmu_en | bus_wdata[NCORE-1:0];
            if (bus_addr == OFS_PMU_CLR)
                pmu_en <= pmu_en & ~bus_wdata[NCORE-1:0];
            for (int c = 0; c < NCORE; c++) begin
                if (bus_addr == reg_ofs(GRP_TMR, c))
                    tmr_ctl[c] <= bus_wdata[CTL_W-1:0];
                if (bus_addr == reg_ofs(GRP_MBX, c))
                    mbx_ctl[c] <= bus_wdata[CTL_W-1:0];
            end
        end
    end

    // read side
    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFS_GPU_ROUTE)
            rd_mux[ROUTE_W-1:0] = gpu_route;
        if (bus_addr == OFS_PMU_SET || bus_addr == OFS_PMU_CLR)
            rd_mux[NCORE-1:0] = pmu_en;
        for (int c = 0; c < NCORE; c++) begin
            if (bus_addr == reg_ofs(GRP_TMR, c))   rd_mux[CTL_W-1:0]  = tmr_ctl[c];
            if (bus_addr == reg_ofs(GRP_MBX, c))   rd_mux[CTL_W-1:0]  = mbx_ctl[c];
            if (bus_addr == reg_ofs(GRP_IPEND, c)) rd_mux[PEND_W-1:0] = irq_pend[c];
            if (bus_addr == reg_ofs(GRP_FPEND, c)) rd_mux[PEND_W-1:0] = fiq_pend[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_mux;
    end

    // R1: enables are clear in the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tmr_ctl == '0 && mbx_ctl == '0 && pmu_en == '0));

    // R7: set port raises every written one
    a_r7_pmu_set: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_PMU_SET) |=>
            ((pmu_en & $past(bus_wdata[NCORE-1:0])) == $past(bus_wdata[NCORE-1:0])));

    // R7: clear port drops every written one
    a_r7_pmu_clr: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_PMU_CLR) |=>
            ((pmu_en & $past(bus_wdata[NCORE-1:0])) == '0));
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
    import cirq_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NCORE*SRC_W-1:0] timer_lines,
    input  logic [NCORE*SRC_W-1:0] mbox_lines,
    input  logic [NCORE-1:0]       pmu_lines,
    input  logic                   gpu_irq,
    input  logic                   gpu_fiq,
    output logic [NCORE-1:0]       core_irq,
    output logic [NCORE-1:0]       core_fiq
);
    logic [NCORE-1:0][CTL_W-1:0]  tmr_ctl;
    logic [NCORE-1:0][CTL_W-1:0]  mbx_ctl;
    logic [NCORE-1:0][PEND_W-1:0] irq_pend;
    logic [NCORE-1:0][PEND_W-1:0] fiq_pend;
    logic [NCORE-1:0]             pmu_en;
    logic [NCORE-1:0]             gpu_irq_seen;
    logic [NCORE-1:0]             pmu_irq_bit;
    gpu_route_t                   gpu_route;

    cirq_regs #(.NCORE(NCORE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pend(irq_pend), .fiq_pend(fiq_pend),
        .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl),
        .gpu_route(gpu_route), .pmu_en(pmu_en)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        cirq_core_route #(.CORE_ID(c)) u_route (
            .clk(clk), .rst(rst),
            .tmr_lines(timer_lines[c*SRC_W +: SRC_W]),
            .mbx_lines(mbox_lines[c*SRC_W +: SRC_W]),
            .tmr_ctl(tmr_ctl[c]), .mbx_ctl(mbx_ctl[c]),
            .gpu_route(gpu_route), .gpu_irq(gpu_irq), .gpu_fiq(gpu_fiq),
            .pmu_en(pmu_en[c]), .pmu_line(pmu_lines[c]),
            .irq_pend(irq_pend[c]), .fiq_pend(fiq_pend[c]),
            .irq_req(core_irq[c]), .fiq_req(core_fiq[c])
        );
        assign gpu_irq_seen[c] = irq_pend[c][BIT_GPU];
        assign pmu_irq_bit[c]  = irq_pend[c][BIT_PMU];
    end

    // R5: the graphics IRQ lands on one core at most
    a_r5_gpu_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gpu_irq_seen));

    // R8: performance-monitor never shows as IRQ
    a_r8_pmu_never_irq: assert property (@(posedge clk) disable iff (rst)
        pmu_irq_bit == '0);
endmodule

// File: tb/core_irq_router_tb.sv
module core_irq_router_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] timer_lines = '0, mbox_lines = '0;
    logic [3:0]  pmu_lines = '0;
    logic        gpu_irq = 1'b0, gpu_fiq = 1'b0;
    logic [3:0]  core_irq, core_fiq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    core_irq_router u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timer_lines(timer_lines), .mbox_lines(mbox_lines), .pmu_lines(pmu_lines),
        .gpu_irq(gpu_irq), .gpu_fiq(gpu_fiq), .core_irq(core_irq), .core_fiq(core_fiq)
    );

    // {core[45:44], tctl[43:36], mctl[35:28], tmr[27:24], mbx[23:20], irq[19:10], fiq[9:0]}
    localparam logic [45:0] VEC [6] = '{
        {2'd0, 8'h0F, 8'h00, 4'hF, 4'hF, 10'h00F, 10'h000},  // R2
        {2'd1, 8'hF0, 8'h00, 4'hF, 4'h0, 10'h000, 10'h00F},  // R3
        {2'd2, 8'h35, 8'h00, 4'hF, 4'h0, 10'h004, 10'h003},  // R3 override
        {2'd3, 8'h00, 8'h0A, 4'h0, 4'hF, 10'h0A0, 10'h000},  // R4
        {2'd0, 8'h00, 8'hC3, 4'h0, 4'h6, 10'h020, 10'h040},  // R4 override
        {2'd1, 8'hFF, 8'hFF, 4'h9, 4'h5, 10'h000, 10'h059}   // R3 R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        // R1: all lines high through reset
        timer_lines = '1; mbox_lines = '1; pmu_lines = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq outputs", 32'(core_irq), 32'h0);
        check("R1 fiq outputs", 32'(core_fiq), 32'h0);
        rd(8'h44, d); check("R1 timer ctl", d, 32'h0);
        rd(8'h10, d); check("R1 pmu mask", d, 32'h0);
        timer_lines = '0; mbox_lines = '0; pmu_lines = '0;

        for (int i = 0; i < 6; i++) begin
            int c;
            logic [45:0] v;
            v = VEC[i];
            c = int'(v[45:44]);
            wr(8'h40 + 8'(4*c), 32'(v[43:36]));
            wr(8'h50 + 8'(4*c), 32'(v[35:28]));
            timer_lines = 16'(v[27:24]) << (4*c);
            mbox_lines  = 16'(v[23:20]) << (4*c);
            rd(8'h60 + 8'(4*c), d); check("R2 R4 irq status", d, 32'(v[19:10]));
            rd(8'h70 + 8'(4*c), d); check("R3 R4 fiq status", d, 32'(v[9:0]));
            check("R9 irq out", 32'(core_irq[c]), 32'(|v[19:10]));
            check("R9 fiq out", 32'(core_fiq[c]), 32'(|v[9:0]));
        end
        timer_lines = '0; mbox_lines = '0;

        // R9: same-cycle response (core1 has all enables on)
        @(negedge clk);
        timer_lines[4] = 1'b1;
        #1 check("R9 fiq rises without edge", 32'(core_fiq), 32'h2);
        timer_lines[4] = 1'b0;
        #1 check("R9 fiq falls without edge", 32'(core_fiq), 32'h0);

        // R10: stride, width and ignored writes
        rd(8'h5C, d); check("R10 mailbox ctl core3", d, 32'h0A);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h4C, d); check("R10 upper bits dropped", d, 32'hFF);
        wr(8'h60, 32'h3FF);
        rd(8'h60, d); check("R10 status write ignored", d, 32'h0);
        rd(8'h20, d); check("R10 unmapped", d, 32'h0);

        // R5 / R6: graphics routing
        gpu_irq = 1'b1; gpu_fiq = 1'b1;
        rd(8'h60, d); check("R5 default core0", d, 32'h100);
        wr(8'h0C, 32'hE);
        rd(8'h68, d); check("R5 irq to core2", d, 32'h100);
        rd(8'h60, d); check("R5 core0 cleared", d, 32'h0);
        rd(8'h7C, d); check("R6 fiq to core3", d, 32'h100);
        rd(8'h78, d); check("R6 core2 no fiq", d, 32'h0);
        check("R5 irq outputs", 32'(core_irq), 32'h4);
        check("R6 fiq outputs", 32'(core_fiq), 32'h8);
        gpu_irq = 1'b0; gpu_fiq = 1'b0;

        // R7 / R8: performance-monitor
        pmu_lines = '1;
        rd(8'h70, d); check("R8 disabled", d, 32'h0);
        wr(8'h10, 32'h5);
        rd(8'h10, d); check("R7 set mask", d, 32'h5);
        rd(8'h70, d); check("R8 fiq bit9 core0", d, 32'h200);
        rd(8'h60, d); check("R8 no irq bit9", d, 32'h0);
        rd(8'h74, d); check("R8 core1 off", d, 32'h0);
        wr(8'h10, 32'h0);
        rd(8'h10, d); check("R7 zero write no effect", d, 32'h5);
        wr(8'h14, 32'h1);
        rd(8'h14, d); check("R7 clear", d, 32'h4);
        rd(8'h70, d); check("R7 core0 cleared", d, 32'h0);
        check("R8 fiq outputs", 32'(core_fiq), 32'h4);
        check("R8 irq outputs", 32'(core_irq), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule